// File: doc/BRIEF.md
# Age-Ordered Wave Issue Scheduler

This block is the arbitration stage between operand collection and execution in a wavefront processor. Each execution resource has its own queue. A candidate instruction enters the queue for its resource, and queues keep their entries in arrival order, so the oldest wave comes first. An entry waits in a "reading operands" state until the register files report that its reads are done. After that the entry may be granted to its resource. Each cycle, every resource grants at most one wave: the oldest entry whose operands are ready, and only if the resource reports that it can accept work.

Two of the resources, a local-memory pipe and a flat-memory pipe, share one bus to local memory. When both would dispatch in the same cycle, the flat instruction gets the bus. The local-memory wave is held back and keeps its place in the queue by age. A wave can own only one instruction inside the stage at a time. That ownership is released when the execute stage reports the instruction as issued.

Top module: `wave_issue_sched`

## Requirements
- R1: A synchronous reset empties every queue and clears all wave ownership. In the cycle after reset no grant is raised, every `disp_stall` bit is high, and a candidate from any wave is accepted.
- R2: A candidate whose wave already owns an entry is refused. When two resources present the same wave in one cycle, only the lowest-numbered resource accepts it. A refused candidate raises `add_stall` for its resource.
- R3: A newly accepted entry is in the reading state and is not granted until operand completion has been reported for it.
- R4: An entry already in a queue becomes ready at a clock edge where `rd_done[w]` is high for its wave `w`. It can then be granted from the next cycle.
- R5: For each resource, at most one wave is granted per cycle. The granted wave is the oldest ready entry, and a grant happens only while `res_ready` for that resource is high.
- R6: A candidate is refused, and `add_stall` for its resource is raised, when `cand_rf_ok` is low or the queue already holds DEPTH entries at the start of the cycle. A grant in that same cycle does not make room.
- R7: If the flat resource (index FLAT_RES, default 3) and the local-memory resource (index LMEM_RES, default 2) would both be granted in one cycle, only the flat resource is granted.
- R8: A local-memory wave that loses the bus stays in its queue at its age position. It is granted ahead of younger ready entries once the bus is free.
- R9: A granted entry leaves its queue at that clock edge. Its wave keeps ownership until a clock edge where `issue_done[w]` is high. Until that edge, new candidates from the wave are refused.
- R10: `disp_stall[r]` is high in exactly the cycles in which resource r is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cand_valid | input | NRES | A candidate is presented for resource r |
| cand_wave | input | NRES*WID | Wave number of the candidate, field r at bits [r*WID +: WID] |
| cand_rf_ok | input | NRES | Register files can serve the operand traffic of the candidate |
| rd_done | input | NWAVE | Operand reads of wave w have completed |
| res_ready | input | NRES | Execution resource r can accept a wave |
| issue_done | input | NWAVE | Execute stage has issued the instruction of wave w |
| grant_valid | output | NRES | Resource r dispatches a wave this cycle |
| grant_wave | output | NRES*WID | Wave dispatched on resource r, field r at bits [r*WID +: WID] |
| add_stall | output | NRES | The candidate for resource r was refused |
| disp_stall | output | NRES | Resource r dispatches nothing this cycle |

## Verification
Directed sequences cover four situations:
- A single wave moving through reading, ready, granted and released. This separates the reading and ready states and shows that ownership ends only when issue is reported.
- The same wave presented on two resources at once. This checks that the lowest-numbered resource takes it.
- Two local-memory waves queued with a flat wave while all three are ready. This shows the flat wave winning the bus and the older local-memory wave then going ahead of the younger one.
- Random candidates, operand completions, resource readiness and issue reports, compared against a bench model of the queues. This catches errors in oldest-first selection, in compaction after removal from the middle of a queue, in full-queue refusal, and in the bus conflict under load.

// File: rtl/wave_issue_sched.sv
module wave_issue_sched #(
  parameter int NRES     = 4,
  parameter int NWAVE    = 8,
  parameter int DEPTH    = 4,
  parameter int LMEM_RES = 2,
  parameter int FLAT_RES = 3,
  localparam int WID = (NWAVE > 1) ? $clog2(NWAVE) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NRES-1:0]     cand_valid,
  input  logic [NRES*WID-1:0] cand_wave,
  input  logic [NRES-1:0]     cand_rf_ok,
  input  logic [NWAVE-1:0]    rd_done,
  input  logic [NRES-1:0]     res_ready,
  input  logic [NWAVE-1:0]    issue_done,
  output logic [NRES-1:0]     grant_valid,
  output logic [NRES*WID-1:0] grant_wave,
  output logic [NRES-1:0]     add_stall,
  output logic [NRES-1:0]     disp_stall
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WID-1:0]   qw   [NRES][DEPTH];
  logic [WID-1:0]   qw_n [NRES][DEPTH];
  logic [DEPTH-1:0] qr   [NRES];
  logic [DEPTH-1:0] qr_n [NRES];
  logic [CW-1:0]    cnt  [NRES];
  logic [CW-1:0]    cnt_n[NRES];
  logic [IW-1:0]    idx  [NRES];
  logic [CW-1:0]    base [NRES];
  logic [NWAVE-1:0] occ, occ_n, claim;
  logic [NRES-1:0]  hit, sel, take;

  always_comb begin
    for (int r = 0; r < NRES; r++) begin
      hit[r] = 1'b0;
      idx[r] = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
        if (CW'(i) < cnt[r] && qr[r][i]) begin
          hit[r] = 1'b1;
          idx[r] = IW'(i);
        end
      end
    end
  end

  assign sel = hit & res_ready;

  always_comb begin
    grant_valid = sel;
    if (sel[FLAT_RES]) grant_valid[LMEM_RES] = 1'b0;
    for (int r = 0; r < NRES; r++)
      grant_wave[r*WID +: WID] = qw[r][idx[r]];
  end

  assign disp_stall = ~grant_valid;

  always_comb begin
    claim = '0;
    take  = '0;
    for (int r = 0; r < NRES; r++) begin
      if (cand_valid[r] && cand_rf_ok[r] && cnt[r] < CW'(DEPTH) &&
          !occ[cand_wave[r*WID +: WID]] && !claim[cand_wave[r*WID +: WID]]) begin
        take[r] = 1'b1;
        claim[cand_wave[r*WID +: WID]] = 1'b1;
      end
    end
  end

  assign add_stall = cand_valid & ~take;
  assign occ_n     = (occ & ~issue_done) | claim;

  always_comb begin
    for (int r = 0; r < NRES; r++) begin
      qw_n[r] = qw[r];
      qr_n[r] = qr[r];
      if (grant_valid[r]) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          if (IW'(i) >= idx[r]) begin
            qw_n[r][i] = qw[r][i+1];
            qr_n[r][i] = qr[r][i+1];
          end
        end
      end
      for (int i = 0; i < DEPTH; i++)
        if (rd_done[qw_n[r][i]]) qr_n[r][i] = 1'b1;
      base[r] = cnt[r] - CW'(grant_valid[r]);
      if (take[r]) begin
        qw_n[r][IW'(base[r])] = cand_wave[r*WID +: WID];
        qr_n[r][IW'(base[r])] = 1'b0;
      end
      cnt_n[r] = base[r] + CW'(take[r]);
    end
  end

  always_ff @(posedge clk) begin
    qw <= qw_n;
    qr <= qr_n;
    if (rst) begin
      occ <= '0;
      for (int r = 0; r < NRES; r++) cnt[r] <= '0;
    end else begin
      occ <= occ_n;
      cnt <= cnt_n;
    end
  end

endmodule

// File: rtl/wave_issue_sched_chk.sv
module wave_issue_sched_chk #(
  parameter int NRES     = 4,
  parameter int NWAVE    = 8,
  parameter int LMEM_RES = 2,
  parameter int FLAT_RES = 3,
  parameter int WID      = 3
) (
  input logic                clk,
  input logic                rst,
  input logic [NRES-1:0]     res_ready,
  input logic [NRES-1:0]     grant_valid,
  input logic [NRES*WID-1:0] grant_wave,
  input logic [NWAVE-1:0]    occ
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (occ == '0 && grant_valid == '0));

  a_r7_flat_wins_bus: assert property (@(posedge clk) disable iff (rst)
    !(grant_valid[LMEM_RES] && grant_valid[FLAT_RES]));

  for (genvar r = 0; r < NRES; r++) begin : g_res
    a_r5_needs_ready: assert property (@(posedge clk) disable iff (rst)
      grant_valid[r] |-> res_ready[r]);
    a_r9_grant_owned: assert property (@(posedge clk) disable iff (rst)
      grant_valid[r] |-> occ[grant_wave[r*WID +: WID]]);
    for (genvar s = r + 1; s < NRES; s++) begin : g_pair
      a_r2_distinct_waves: assert property (@(posedge clk) disable iff (rst)
        (grant_valid[r] && grant_valid[s]) |->
          grant_wave[r*WID +: WID] != grant_wave[s*WID +: WID]);
    end
  end

endmodule

bind wave_issue_sched wave_issue_sched_chk #(
  .NRES(NRES), .NWAVE(NWAVE), .LMEM_RES(LMEM_RES), .FLAT_RES(FLAT_RES), .WID(WID)
) u_chk (
  .clk(clk), .rst(rst), .res_ready(res_ready),
  .grant_valid(grant_valid), .grant_wave(grant_wave), .occ(occ)
);

// File: tb/test_wave_issue_sched.sv
`timescale 1ns/100ps
module test_wave_issue_sched;
  localparam int NR = 4, NW = 8, DP = 4, WD = 3, L = 2, F = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NR-1:0]    cv = '0, ok = '0, rr = '0;
  logic [NR*WD-1:0] cw = '0;
  logic [NW-1:0]    rd = '0, idn = '0;
  logic [NR-1:0]    gv, ast, dst;
  logic [NR*WD-1:0] gw;

  int tests = 0, fails = 0;

  int mw [NR][DP];
  bit mr [NR][DP];
  int mc [NR];
  bit [NW-1:0] mocc, outq, ecl;
  bit [NR-1:0] eg, ea;
  int eidx [NR];
  int ew [NR];

  always #2 clk = ~clk;

  wave_issue_sched #(.NRES(NR), .NWAVE(NW), .DEPTH(DP), .LMEM_RES(L), .FLAT_RES(F)) i_wave_issue_sched (
    .clk(clk), .rst(rst), .cand_valid(cv), .cand_wave(cw), .cand_rf_ok(ok),
    .rd_done(rd), .res_ready(rr), .issue_done(idn),
    .grant_valid(gv), .grant_wave(gw), .add_stall(ast), .disp_stall(dst));

  task automatic chk(input bit good, input string req, input int act, input int exp);
    tests++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic predict();
    bit [NW-1:0] cl = '0;
    for (int r = 0; r < NR; r++) begin
      eg[r] = 1'b0; eidx[r] = 0;
      for (int i = mc[r] - 1; i >= 0; i--)
        if (mr[r][i]) begin eg[r] = 1'b1; eidx[r] = i; end
      eg[r] = eg[r] & rr[r];
      ew[r] = mw[r][eidx[r]];
    end
    if (eg[F]) eg[L] = 1'b0;
    ea = '0;
    for (int r = 0; r < NR; r++) begin
      int w = int'(cw[r*WD +: WD]);
      if (cv[r] && ok[r] && mc[r] < DP && !mocc[w] && !cl[w]) begin
        ea[r] = 1'b1; cl[w] = 1'b1;
      end
    end
    ecl = cl;
  endtask

  task automatic compare();
    for (int r = 0; r < NR; r++) begin
      chk(gv[r] == eg[r], (r == L) ? "R7 grant" : "R5 grant", int'(gv[r]), int'(eg[r]));
      if (eg[r]) chk(int'(gw[r*WD +: WD]) == ew[r], "R8 grant wave", int'(gw[r*WD +: WD]), ew[r]);
      chk(ast[r] == (cv[r] & ~ea[r]), "R6 add stall", int'(ast[r]), int'(cv[r] & ~ea[r]));
      chk(dst[r] == ~eg[r], "R10 disp stall", int'(dst[r]), int'(~eg[r]));
    end
  endtask

  task automatic advance();
    outq = outq & ~idn;
    for (int r = 0; r < NR; r++) begin
      if (eg[r]) begin
        for (int i = eidx[r]; i < mc[r] - 1; i++) begin
          mw[r][i] = mw[r][i+1]; mr[r][i] = mr[r][i+1];
        end
        mc[r]--;
        outq[ew[r]] = 1'b1;
      end
      for (int i = 0; i < mc[r]; i++) if (rd[mw[r][i]]) mr[r][i] = 1'b1;
      if (ea[r]) begin
        mw[r][mc[r]] = int'(cw[r*WD +: WD]); mr[r][mc[r]] = 1'b0; mc[r]++;
      end
    end
    mocc = (mocc & ~idn) | ecl;
  endtask

  task automatic cyc();
    #1;
    if (!rst) begin predict(); compare(); end
    @(posedge clk);
    if (rst) begin
      mocc = '0; outq = '0;
      for (int r = 0; r < NR; r++) mc[r] = 0;
    end else advance();
    @(negedge clk);
  endtask

  task automatic quiet();
    cv = '0; ok = '1; rr = '0; rd = '0; idn = '0; cw = '0;
  endtask

  initial begin
    #(200000 * 4);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    quiet(); rst = 1'b1;
    cyc(); cyc();
    rst = 1'b0;
    rr = '1;
    #0.5;
    chk(dst == '1 && gv == '0, "R1 reset idle", int'(dst), 15);
    cyc();

    quiet(); cv[0] = 1'b1; cw[0 +: WD] = 3'd1; cyc();
    quiet(); rr = '1;
    #0.5;
    chk(gv[0] == 1'b0, "R3 busy entry not granted", int'(gv[0]), 0);
    rd[1] = 1'b1; cyc();
    quiet(); rr = '1; cv[1] = 1'b1; cw[WD +: WD] = 3'd1;
    #0.5;
    chk(gv[0] == 1'b1 && gw[0 +: WD] == 3'd1, "R4 ready entry granted", int'(gv[0]), 1);
    chk(ast[1] == 1'b1, "R2 owned wave refused", int'(ast[1]), 1);
    cyc();
    quiet(); idn[1] = 1'b1; cv[1] = 1'b1; cw[WD +: WD] = 3'd1;
    #0.5;
    chk(ast[1] == 1'b1, "R9 still owned at issue edge", int'(ast[1]), 1);
    cyc();
    quiet(); cv[1] = 1'b1; cw[WD +: WD] = 3'd1;
    #0.5;
    chk(ast[1] == 1'b0, "R9 released after issue", int'(ast[1]), 0);
    cyc();
    quiet(); cv[1:0] = 2'b11; cw[0 +: WD] = 3'd5; cw[WD +: WD] = 3'd5;
    #0.5;
    chk(ast[1:0] == 2'b10, "R2 lowest resource takes wave", int'(ast[1:0]), 2);
    cyc();

    quiet(); cv[L] = 1'b1; cw[L*WD +: WD] = 3'd2; cyc();
    quiet(); cv[L] = 1'b1; cw[L*WD +: WD] = 3'd3; cv[F] = 1'b1; cw[F*WD +: WD] = 3'd4; cyc();
    quiet(); rd[2] = 1'b1; rd[3] = 1'b1; rd[4] = 1'b1; cyc();
    quiet(); rr[L] = 1'b1; rr[F] = 1'b1;
    #0.5;
    chk(gv[F] && gw[F*WD +: WD] == 3'd4 && !gv[L], "R7 flat wins bus", int'(gv[L]), 0);
    cyc();
    quiet(); rr[L] = 1'b1; rr[F] = 1'b1;
    #0.5;
    chk(gv[L] && gw[L*WD +: WD] == 3'd2, "R8 loser keeps age", int'(gw[L*WD +: WD]), 2);
    cyc();

    for (int n = 0; n < 4000; n++) begin
      for (int r = 0; r < NR; r++) begin
        cv[r] = ($urandom % 3) != 0;
        cw[r*WD +: WD] = WD'($urandom % NW);
        ok[r] = ($urandom % 8) != 0;
        rr[r] = ($urandom % 4) != 0;
      end
      rd  = NW'($urandom) & NW'($urandom);
      idn = NW'($urandom) & outq;
      cyc();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule